// File: doc/BRIEF.md
# Accumulator Word Extractor with Rounding and Saturation

This unit pulls a single signed 32-bit word out of a 64-bit accumulator that is supplied as two 32-bit halves (an upper word and a lower word). A 5-bit amount selects how far the accumulator is shifted right before the word is taken. Three extraction styles are offered: plain truncation, round-to-nearest (half-LSB added before the cut), and rounding followed by clamping to the signed 32-bit range.

Internally the shifted value is formed with one guard bit below the result and one extra copy of the accumulator sign above it, so rounding and range checking see 65 bits. Whenever an extraction does not fit in a signed 32-bit word, a sticky flag in bit 23 of a 32-bit status word is raised and stays up until a clear strobe arrives. The extracted word and the flag are registered and change on the clock edge that samples a valid strobe.

Top module: `acc_extract`

## Requirements
- R1: After reset, `resultOut` is 0 and `statusOut` is 0.
- R2: With `modeIn` = 2'b00 (truncate), `resultOut` is bits 32..1 of the intermediate, where the intermediate is the 64-bit accumulator {hiIn, loIn} arithmetically shifted right by `shiftIn` minus one, with no rounding.
- R3: With `shiftIn` = 0, the intermediate is the accumulator shifted left by one, so truncate mode returns `loIn` unchanged.
- R4: With `modeIn` = 2'b01 (round), one is added to the 64-bit intermediate before the result word is taken.
- R5: When the rounding addition wraps the 64-bit intermediate to zero, the carry flips the separate sign bit above it; an all-ones accumulator with shift 31 gives 0 in round and saturate modes with no overflow, and 0xFFFFFFFF in truncate mode.
- R6: Overflow is flagged when the sign bit above the intermediate together with intermediate bits 63..32 is neither all zeros nor all ones; it sets `statusOut[23]`, which then stays at 1.
- R7: With `modeIn` = 2'b10 (round and saturate), an overflowing extraction yields 0x7FFFFFFF when the sign bit above the intermediate is 0 and 0x80000000 when it is 1; {hiIn,loIn} = 0x80000000_00000000 with shift 31 gives 0x80000000 with overflow.
- R8: `modeIn` = 2'b11 behaves exactly as truncate.
- R9: `resultOut` and the flag update on the rising clock edge where `validIn` is 1; with `validIn` at 0, `resultOut` holds its value.
- R10: `statClrIn` at 1 clears `statusOut[23]` on the next edge and wins over an overflow from an extraction in the same cycle.
- R11: All bits of `statusOut` other than bit 23 read 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Starts an extraction this cycle |
| modeIn | input | 2 | 00 truncate, 01 round, 10 round and saturate, 11 as truncate |
| shiftIn | input | 5 | Right-shift amount |
| hiIn | input | 32 | Upper half of the accumulator |
| loIn | input | 32 | Lower half of the accumulator |
| statClrIn | input | 1 | Clears the sticky overflow flag |
| resultOut | output | 32 | Registered extracted word |
| statusOut | output | 32 | Status word, sticky overflow in bit 23 |

## Verification
The bench targets the rounding carry that wraps the whole 64-bit intermediate: a design that drops the carry into the extra sign bit would report overflow and, in saturate mode, clamp an all-ones accumulator to a large value instead of returning 0. The most negative accumulator at shift 31 checks the clamp direction; taking the sign from the wrong place would give 0x7FFFFFFF. Shift 0 checks the left-shift special case, which a naive shift by minus one would corrupt, and a clear issued in the same cycle as an overflowing extraction checks the clear priority. Random accumulators and shifts in all four mode codes are compared against an independent 65-bit model.

// File: rtl/acx_pkg.sv
package acx_pkg;
  parameter int FLAG_BIT = 23;

  typedef enum logic [1:0] {
    MODE_TRUNC = 2'b00,
    MODE_ROUND = 2'b01,
    MODE_SAT   = 2'b10,
    MODE_RSVD  = 2'b11
  } acxMode_t;

  typedef struct packed {
    logic load;
    logic roundEn;
    logic satEn;
  } acxStrobe_t;
endpackage

// File: rtl/acx_ctrl.sv
module acx_ctrl
  import acx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic [1:0] modeIn,
  input  logic       statClrIn,
  input  logic       ovfIn,
  output acxStrobe_t strobeOut,
  output logic       flagOut
);
  acxMode_t modeSel;
  logic     flagQ;

  assign modeSel = acxMode_t'(modeIn);

  always_comb begin
    strobeOut.load    = validIn;
    strobeOut.roundEn = (modeSel == MODE_ROUND) || (modeSel == MODE_SAT);
    strobeOut.satEn   = (modeSel == MODE_SAT);
  end

  // Clear wins over a set arriving in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)                 flagQ <= 1'b0;
    else if (statClrIn)        flagQ <= 1'b0;
    else if (validIn && ovfIn) flagQ <= 1'b1;
  end

  assign flagOut = flagQ;
endmodule

// File: rtl/acx_datapath.sv
module acx_datapath
  import acx_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  acxStrobe_t         strobeIn,
  input  logic [SHIFT_W-1:0] shiftIn,
  input  logic [WORD_W-1:0]  hiIn,
  input  logic [WORD_W-1:0]  loIn,
  output logic               ovfOut,
  output logic [WORD_W-1:0]  resultOut
);
  localparam int ACC_W = 2 * WORD_W;
  localparam int UP_W  = WORD_W + 1;

  logic signed [ACC_W-1:0] accS;
  logic [SHIFT_W-1:0]      shiftM1;
  logic [ACC_W-1:0]        preLow;
  logic [ACC_W-1:0]        lowR;
  logic                    signTop;
  logic                    topR;
  logic                    wrapAll;
  logic [UP_W-1:0]         upperBits;
  logic [WORD_W-1:0]       truncWord;
  logic [WORD_W-1:0]       satWord;
  logic [WORD_W-1:0]       nextWord;
  logic [WORD_W-1:0]       resultQ;
  logic                    unusedGuard;

  assign accS    = signed'({hiIn, loIn});
  assign shiftM1 = shiftIn - SHIFT_W'(1);
  assign signTop = accS[ACC_W-1];

  // Keep one guard bit below the extracted word.
  always_comb begin
    if (shiftIn == '0) preLow = ACC_W'(accS <<< 1);
    else               preLow = ACC_W'(accS >>> shiftM1);
  end

  // Rounding: a wrap of the low 64 bits carries into the sign copy.
  assign wrapAll = &preLow;
  assign lowR    = strobeIn.roundEn ? (preLow + ACC_W'(1)) : preLow;
  assign topR    = signTop ^ (strobeIn.roundEn & wrapAll);

  assign upperBits = {topR, lowR[ACC_W-1:WORD_W]};
  assign ovfOut    = ~((~|upperBits) | (&upperBits));

  assign truncWord   = lowR[WORD_W:1];
  assign unusedGuard = lowR[0];
  assign satWord     = topR ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
  assign nextWord    = (strobeIn.satEn && ovfOut) ? satWord : truncWord;

  always_ff @(posedge clk) begin
    if (!rstN)              resultQ <= '0;
    else if (strobeIn.load) resultQ <= nextWord;
  end

  assign resultOut = resultQ;
endmodule

// File: rtl/acc_extract.sv
module acc_extract
  import acx_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               validIn,
  input  logic [1:0]         modeIn,
  input  logic [SHIFT_W-1:0] shiftIn,
  input  logic [WORD_W-1:0]  hiIn,
  input  logic [WORD_W-1:0]  loIn,
  input  logic               statClrIn,
  output logic [WORD_W-1:0]  resultOut,
  output logic [WORD_W-1:0]  statusOut
);
  acxStrobe_t strobe;
  logic       ovf;
  logic       flag;

  acx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .modeIn(modeIn),
    .statClrIn(statClrIn), .ovfIn(ovf), .strobeOut(strobe), .flagOut(flag)
  );

  acx_datapath #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobeIn(strobe), .shiftIn(shiftIn),
    .hiIn(hiIn), .loIn(loIn), .ovfOut(ovf), .resultOut(resultOut)
  );

  for (genvar i = 0; i < WORD_W; i++) begin : gStatus
    if (i == FLAG_BIT) begin : gFlag
      assign statusOut[i] = flag;
    end else begin : gZero
      assign statusOut[i] = 1'b0;
    end
  end
endmodule

// File: rtl/acx_checker.sv
module acx_checker
  import acx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic              statClrIn,
  input logic [WORD_W-1:0] resultOut,
  input logic [WORD_W-1:0] statusOut
);
  logic [WORD_W-1:0] otherMask;
  assign otherMask = ~(WORD_W'(1) << FLAG_BIT);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(resultOut));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    statClrIn |=> !statusOut[FLAG_BIT]);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[FLAG_BIT] && !statClrIn) |=> statusOut[FLAG_BIT]);

  assert_set_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!statusOut[FLAG_BIT] && !validIn) |=> !statusOut[FLAG_BIT]);

  assert_zero_bits_R11: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut & otherMask) == '0);
endmodule

bind acc_extract acx_checker #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .validIn(validIn), .statClrIn(statClrIn),
  .resultOut(resultOut), .statusOut(statusOut)
);

// File: tb/sim_acc_extract.sv
module sim_acc_extract;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [1:0]  modeIn = 2'b00;
  logic [4:0]  shiftIn = '0;
  logic [31:0] hiIn = '0;
  logic [31:0] loIn = '0;
  logic        statClrIn = 1'b0;
  logic [31:0] resultOut;
  logic [31:0] statusOut;

  int compared = 0;
  int mismatched = 0;
  logic modelFlag = 1'b0;

  acc_extract u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .modeIn(modeIn),
    .shiftIn(shiftIn), .hiIn(hiIn), .loIn(loIn), .statClrIn(statClrIn),
    .resultOut(resultOut), .statusOut(statusOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // Returns {overflow, word} from 65-bit arithmetic.
  function automatic logic [32:0] refCalc(input logic [1:0] m, input logic [4:0] s,
                                          input logic [31:0] h, input logic [31:0] l);
    logic signed [63:0] a;
    logic [63:0] mid;
    logic        sgn;
    logic [32:0] up;
    logic        ov;
    logic [31:0] w;
    a   = signed'({h, l});
    sgn = a[63];
    if (s == 5'd0) mid = a <<< 1;
    else           mid = a >>> (s - 5'd1);
    if (m == 2'b01 || m == 2'b10) begin
      mid = mid + 64'd1;
      if (mid == 64'd0) sgn = ~sgn;
    end
    up = {sgn, mid[63:32]};
    ov = (up != 33'd0) && (up != {33{1'b1}});
    w  = mid[32:1];
    if (m == 2'b10 && ov) w = sgn ? 32'h8000_0000 : 32'h7FFF_FFFF;
    return {ov, w};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one cycle, then compares outputs at the following negedge.
  task automatic runOp(input string tag, input logic v, input logic [1:0] m,
                       input logic [4:0] s, input logic [31:0] h, input logic [31:0] l,
                       input logic clr, input logic [31:0] expWord);
    logic [32:0] r;
    @(negedge clk);
    validIn = v; modeIn = m; shiftIn = s; hiIn = h; loIn = l; statClrIn = clr;
    r = refCalc(m, s, h, l);
    if (clr) modelFlag = 1'b0;
    else if (v && r[32]) modelFlag = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(tag, resultOut, expWord);
    check({tag, " status R6 R11"}, statusOut, 32'(modelFlag) << 23);
    validIn = 1'b0; statClrIn = 1'b0;
  endtask

  initial begin
    logic [31:0] lastWord;
    void'($urandom(32'd20240917));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset result", resultOut, 32'd0);
    check("R1 reset status", statusOut, 32'd0);
    rstN = 1'b1;

    // R7: most negative accumulator clamps low, flag set (R6)
    runOp("R7 sat negative", 1'b1, 2'b10, 5'd31, 32'h8000_0000, 32'h0, 1'b0, 32'h8000_0000);
    runOp("R10 clear", 1'b0, 2'b00, 5'd0, 32'h0, 32'h0, 1'b1, 32'h8000_0000);
    // R5: rounding wrap of all-ones accumulator
    runOp("R5 round wrap", 1'b1, 2'b01, 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'h0);
    runOp("R5 sat wrap", 1'b1, 2'b10, 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'h0);
    runOp("R2 R5 trunc all ones", 1'b1, 2'b00, 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF);
    // R4 / R2 / R8 small value, shift 1
    runOp("R4 round half", 1'b1, 2'b01, 5'd1, 32'h0, 32'h3, 1'b0, 32'h2);
    runOp("R2 trunc half", 1'b1, 2'b00, 5'd1, 32'h0, 32'h3, 1'b0, 32'h1);
    runOp("R8 reserved mode", 1'b1, 2'b11, 5'd1, 32'h0, 32'h3, 1'b0, 32'h1);
    // R7 positive clamp
    runOp("R7 sat positive", 1'b1, 2'b10, 5'd4, 32'h4000_0000, 32'h0, 1'b0, 32'h7FFF_FFFF);
    // R3 shift zero returns low word
    runOp("R3 shift zero", 1'b1, 2'b00, 5'd0, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 32'h9ABC_DEF0);
    // R9 hold with valid low
    runOp("R9 hold", 1'b0, 2'b01, 5'd3, 32'hDEAD_BEEF, 32'h1111_2222, 1'b0, 32'h9ABC_DEF0);
    // R10 clear beats set in the same cycle; result still loads
    runOp("R10 clear priority", 1'b1, 2'b10, 5'd31, 32'h8000_0000, 32'h0, 1'b1, 32'h8000_0000);

    lastWord = resultOut;
    for (int i = 0; i < 500; i++) begin
      logic        v;
      logic        clr;
      logic [1:0]  m;
      logic [4:0]  s;
      logic [31:0] h;
      logic [31:0] l;
      logic [32:0] r;
      logic [31:0] expW;
      v   = ($urandom % 8) != 0;
      clr = ($urandom % 16) == 0;
      m   = 2'($urandom);
      s   = 5'($urandom);
      h   = $urandom;
      l   = $urandom;
      if (($urandom % 4) == 0) h = {32{h[0]}};
      r    = refCalc(m, s, h, l);
      expW = v ? r[31:0] : lastWord;
      runOp("R2 R4 R7 R8 R9 random", v, m, s, h, l, clr, expW);
      lastWord = expW;
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule